// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a bus master that runs the command sequences of a parallel NOR flash driven through two unlock writes. A single start pulse picks one of three jobs: program one word, erase one sector, or return the bank to array-read mode. The sequencer issues every command write, reads status back from the flash and polls it. It watches the time spent polling and ends with a two-bit result code. Software or a higher-level controller only presents the bank base, the target word address and the data, then waits for `done`.

Before a program, the word is read and compared against the new data. A word that cannot be reached by clearing bits alone is refused at once, with no command sent. Otherwise the unlock pair and the program command are written, followed by the data. Bit 7 of the read-back, and also bit 23 when two 16-bit devices share a 32-bit bank, is compared with the data until the two agree or the program timer runs out. An erase uses two unlock pairs around the erase-setup command and then names the sector. It waits a fixed settle time before the first status read, then polls until bit 7 reads one. Either timeout sends the read-array command and reports failure. The flash write-enable gate is open only while commands may be issued.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fl_rd`, `fl_wr` and `fl_wgate` are all low.
- R2: Program (op 0) on an erased-enough word writes, in order, 0x00AA to base+0x555, 0x0055 to base+0x2AA, 0x00A0 to base+0x555, then the data to the target. With ALT_UNLOCK set, the first offset is 0x554 and the second 0x2AB.
- R3: Program first reads the target. If (current & data) != data, it ends with result 2, makes no write strobe and never opens the write gate.
- R4: Program polling reads the target repeatedly and stops at the first read whose bit 7 equals bit 7 of the data (bits 7 and 23 with LANES=2). It then ends with result 0.
- R5: If program polling has not matched by PROG_TMO clocks into the polling phase, 0x00F0 is written to the target and the result is 1.
- R6: Erase (op 1) writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA relative to base, then 0x30 to the sector address. No read strobe starts within ERASE_SETTLE clocks of the last write. Polling ends with result 0 on the first read with bit 7 set.
- R7: If erase polling has not seen bit 7 set by ERASE_TMO clocks into polling, 0x00F0 is written to the bank base and the result is 1.
- R8: Reset-to-read (op 2, and op 3 treated the same) writes only 0x00F0 to the bank base and returns result 0.
- R9: A write strobe occurs only while `fl_wgate` is high, and the gate is low whenever the block is idle.
- R10: `busy` rises the clock after start and stays high through the single-cycle `done` pulse. It falls the next clock. A start while busy is ignored.
- R11: Every bus cycle holds its strobe for BUS_WAIT+1 clocks with a stable address and data. Read and write strobes never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| op | input | 2 | 0 program, 1 sector erase, 2 or 3 reset-to-read |
| bank_base | input | ADDR_W | Word address of the bank base |
| target_addr | input | ADDR_W | Word to program or sector start to erase |
| wr_data | input | 16*LANES | Data to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 2 | 0 ok, 1 timeout, 2 not erased |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | 16*LANES | Flash write data |
| fl_rdata | input | 16*LANES | Flash read data |
| fl_rd | output | 1 | Read strobe |
| fl_wr | output | 1 | Write strobe |
| fl_wgate | output | 1 | Bank write-enable gate |

## Verification
The two events that can fall in the same cycle are a passing status read and the expiry of the polling timer. Both are judged at the end of the same read strobe, and a passing read must win. The bench provokes the timeout side by holding the status at busy far past the limit, and expects the reset write and code 1. It covers the pass side by letting the status flip after a known number of reads, and expects an exact read count and code 0. A start pulse arriving mid-operation is also injected; the write log must show only the original sequence.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG      = 2'd0,
    OP_ERASE     = 2'd1,
    OP_RESET     = 2'd2,
    OP_RESET_ALT = 2'd3
  } nor_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHK_GO,
    S_CHK_WT,
    S_CMD_GO,
    S_CMD_WT,
    S_SETTLE,
    S_POLL_GO,
    S_POLL_WT,
    S_ABT_GO,
    S_ABT_WT,
    S_FINISH
  } seq_state_e;

  localparam logic [1:0] RES_OK          = 2'd0;
  localparam logic [1:0] RES_TIMEOUT     = 2'd1;
  localparam logic [1:0] RES_NOT_ERASED  = 2'd2;

  localparam logic [7:0] CMD_UNLK_A      = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B      = 8'h55;
  localparam logic [7:0] CMD_PROG        = 8'hA0;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h80;
  localparam logic [7:0] CMD_SECTOR      = 8'h30;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hF0;

endpackage

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LANES      = 1,
  parameter bit ALT_UNLOCK = 1'b0
) (
  input  nor_op_e                 op,
  input  logic [2:0]              step,
  input  logic [ADDR_W-1:0]       base,
  input  logic [ADDR_W-1:0]       target,
  input  logic [16*LANES-1:0]     wdata,
  output logic [ADDR_W-1:0]       cmd_addr,
  output logic [16*LANES-1:0]     cmd_data,
  output logic                    cmd_last
);

  localparam int DATA_W = 16 * LANES;
  localparam logic [ADDR_W-1:0] OFS_FIRST  = ALT_UNLOCK ? ADDR_W'(12'h554) : ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] OFS_SECOND = ALT_UNLOCK ? ADDR_W'(12'h2AB) : ADDR_W'(12'h2AA);

  function automatic logic [DATA_W-1:0] lane_rep(input logic [7:0] c);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < LANES; i++) begin
      v[16*i +: 8] = c;
    end
    return v;
  endfunction

  logic [ADDR_W-1:0] a_first;
  logic [ADDR_W-1:0] a_second;

  assign a_first  = base + OFS_FIRST;
  assign a_second = base + OFS_SECOND;

  always_comb begin
    cmd_addr = base;
    cmd_data = lane_rep(CMD_READ_ARRAY);
    cmd_last = 1'b0;
    unique case (op)
      OP_PROG: begin
        unique case (step)
          3'd0: begin cmd_addr = a_first;  cmd_data = lane_rep(CMD_UNLK_A); end
          3'd1: begin cmd_addr = a_second; cmd_data = lane_rep(CMD_UNLK_B); end
          3'd2: begin cmd_addr = a_first;  cmd_data = lane_rep(CMD_PROG);   end
          default: begin
            cmd_addr = target;
            cmd_data = wdata;
            cmd_last = 1'b1;
          end
        endcase
      end
      OP_ERASE: begin
        unique case (step)
          3'd0: begin cmd_addr = a_first;  cmd_data = lane_rep(CMD_UNLK_A);      end
          3'd1: begin cmd_addr = a_second; cmd_data = lane_rep(CMD_UNLK_B);      end
          3'd2: begin cmd_addr = a_first;  cmd_data = lane_rep(CMD_ERASE_SETUP); end
          3'd3: begin cmd_addr = a_first;  cmd_data = lane_rep(CMD_UNLK_A);      end
          3'd4: begin cmd_addr = a_second; cmd_data = lane_rep(CMD_UNLK_B);      end
          default: begin
            cmd_addr = target;
            cmd_data = lane_rep(CMD_SECTOR);
            cmd_last = 1'b1;
          end
        endcase
      end
      default: begin
        cmd_addr = base;
        cmd_data = lane_rep(CMD_READ_ARRAY);
        cmd_last = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int BUS_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_wr,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              fl_rd,
  output logic              fl_wr,
  output logic              cyc_last
);

  localparam int CW = (BUS_WAIT > 0) ? $clog2(BUS_WAIT + 1) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(BUS_WAIT);

  logic              active_q, active_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              load_en;

  assign load_en  = go;
  assign cyc_last = active_q && (cnt_q == CNT_END);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (go) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q) begin
      if (cnt_q == CNT_END) begin
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      wr_q   <= go_wr;
      addr_q <= go_addr;
      data_q <= go_data;
    end
  end

  assign fl_addr  = addr_q;
  assign fl_wdata = data_q;
  assign fl_wr    = active_q && wr_q;
  assign fl_rd    = active_q && !wr_q;

endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!expired) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LANES        = 1,
  parameter int BUS_WAIT     = 2,
  parameter bit ALT_UNLOCK   = 1'b0,
  parameter int PROG_TMO     = 2000,
  parameter int ERASE_TMO    = 1000000,
  parameter int ERASE_SETTLE = 500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            op,
  input  logic [ADDR_W-1:0]     bank_base,
  input  logic [ADDR_W-1:0]     target_addr,
  input  logic [16*LANES-1:0]   wr_data,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            result,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [16*LANES-1:0]   fl_wdata,
  input  logic [16*LANES-1:0]   fl_rdata,
  output logic                  fl_rd,
  output logic                  fl_wr,
  output logic                  fl_wgate
);

  localparam int DATA_W = 16 * LANES;
  localparam int TMAX_A = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
  localparam int TMAX   = (TMAX_A > ERASE_SETTLE) ? TMAX_A : ERASE_SETTLE;
  localparam int TW     = $clog2(TMAX + 1) + 1;

  function automatic logic [DATA_W-1:0] poll_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      m[16*i + 7] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] lane_rep(input logic [7:0] c);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < LANES; i++) begin
      v[16*i +: 8] = c;
    end
    return v;
  endfunction

  localparam logic [DATA_W-1:0] POLL_MASK = poll_mask_f();

  seq_state_e        state_q, state_d;
  nor_op_e           op_q;
  logic [ADDR_W-1:0] base_q, tgt_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        step_q, step_d;
  logic [1:0]        res_q, res_d;
  logic              cap_en;

  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              rom_last;

  logic              bus_go, bus_wr, bus_last;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;

  logic              tmr_clr, tmr_exp;
  logic [TW-1:0]     tmr_limit;

  logic              erased_ok, prog_poll_ok, erase_poll_ok, poll_ok;

  nor_cmd_rom #(
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .ALT_UNLOCK(ALT_UNLOCK)
  ) u_rom (
    .op      (op_q),
    .step    (step_q),
    .base    (base_q),
    .target  (tgt_q),
    .wdata   (data_q),
    .cmd_addr(rom_addr),
    .cmd_data(rom_data),
    .cmd_last(rom_last)
  );

  nor_bus_cycle #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BUS_WAIT(BUS_WAIT)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (bus_go),
    .go_wr   (bus_wr),
    .go_addr (bus_addr),
    .go_data (bus_data),
    .fl_addr (fl_addr),
    .fl_wdata(fl_wdata),
    .fl_rd   (fl_rd),
    .fl_wr   (fl_wr),
    .cyc_last(bus_last)
  );

  nor_poll_timer #(
    .TW(TW)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .limit  (tmr_limit),
    .expired(tmr_exp)
  );

  // status decode on the data returned in the last clock of a read cycle
  assign erased_ok     = ((fl_rdata & data_q) == data_q);
  assign prog_poll_ok  = (((fl_rdata ^ data_q) & POLL_MASK) == '0);
  assign erase_poll_ok = ((fl_rdata & POLL_MASK) == POLL_MASK);
  assign poll_ok       = (op_q == OP_ERASE) ? erase_poll_ok : prog_poll_ok;

  assign tmr_limit = (state_q == S_SETTLE) ? TW'(ERASE_SETTLE) :
                     (op_q == OP_ERASE)    ? TW'(ERASE_TMO)    : TW'(PROG_TMO);

  // counter restarts on entry to the settle wait and on entry to polling
  assign tmr_clr = (state_d != state_q) &&
                   ((state_d == S_SETTLE) ||
                    ((state_d == S_POLL_GO) && (state_q != S_POLL_WT)));

  always_comb begin
    bus_go   = 1'b0;
    bus_wr   = 1'b0;
    bus_addr = tgt_q;
    bus_data = data_q;
    unique case (state_q)
      S_CHK_GO, S_POLL_GO: begin
        bus_go = 1'b1;
      end
      S_CMD_GO: begin
        bus_go   = 1'b1;
        bus_wr   = 1'b1;
        bus_addr = rom_addr;
        bus_data = rom_data;
      end
      S_ABT_GO: begin
        bus_go   = 1'b1;
        bus_wr   = 1'b1;
        bus_addr = (op_q == OP_ERASE) ? base_q : tgt_q;
        bus_data = lane_rep(CMD_READ_ARRAY);
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    res_d   = res_q;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          step_d  = '0;
          state_d = (nor_op_e'(op) == OP_PROG) ? S_CHK_GO : S_CMD_GO;
        end
      end
      S_CHK_GO: state_d = S_CHK_WT;
      S_CHK_WT: begin
        if (bus_last) begin
          if (erased_ok) begin
            state_d = S_CMD_GO;
          end else begin
            res_d   = RES_NOT_ERASED;
            state_d = S_FINISH;
          end
        end
      end
      S_CMD_GO: state_d = S_CMD_WT;
      S_CMD_WT: begin
        if (bus_last) begin
          if (!rom_last) begin
            step_d  = step_q + 1'b1;
            state_d = S_CMD_GO;
          end else if (op_q == OP_PROG) begin
            state_d = S_POLL_GO;
          end else if (op_q == OP_ERASE) begin
            state_d = S_SETTLE;
          end else begin
            res_d   = RES_OK;
            state_d = S_FINISH;
          end
        end
      end
      S_SETTLE: begin
        if (tmr_exp) state_d = S_POLL_GO;
      end
      S_POLL_GO: state_d = S_POLL_WT;
      S_POLL_WT: begin
        if (bus_last) begin
          if (poll_ok) begin
            res_d   = RES_OK;
            state_d = S_FINISH;
          end else if (tmr_exp) begin
            state_d = S_ABT_GO;
          end else begin
            state_d = S_POLL_GO;
          end
        end
      end
      S_ABT_GO: state_d = S_ABT_WT;
      S_ABT_WT: begin
        if (bus_last) begin
          res_d   = RES_TIMEOUT;
          state_d = S_FINISH;
        end
      end
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  assign cap_en = (state_q == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      res_q   <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_RESET;
      base_q <= '0;
      tgt_q  <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      op_q   <= nor_op_e'(op);
      base_q <= bank_base;
      tgt_q  <= target_addr;
      data_q <= wr_data;
    end
  end

  assign busy   = (state_q != S_IDLE);
  assign done   = (state_q == S_FINISH);
  assign result = res_q;

  always_comb begin
    unique case (state_q)
      S_CMD_GO, S_CMD_WT, S_SETTLE, S_POLL_GO, S_POLL_WT,
      S_ABT_GO, S_ABT_WT: fl_wgate = 1'b1;
      default:            fl_wgate = 1'b0;
    endcase
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int BUS_WAIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_wdata,
  input logic              fl_rd,
  input logic              fl_wr,
  input logic              fl_wgate
);

  logic        strobe;
  logic [15:0] run_q;

  assign strobe = fl_rd || fl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (strobe) begin
      run_q <= run_q + 16'd1;
    end else begin
      run_q <= '0;
    end
  end

  a_r9_write_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr |-> fl_wgate);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_wr && !fl_rd && !fl_wgate));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_wr && fl_rd));

  a_r11_cycle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  a_r11_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && (run_q != 16'd0)) |-> (run_q == 16'(BUS_WAIT + 1)));

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (16 * LANES),
  .BUS_WAIT(BUS_WAIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .fl_addr (fl_addr),
  .fl_wdata(fl_wdata),
  .fl_rd   (fl_rd),
  .fl_wr   (fl_wr),
  .fl_wgate(fl_wgate)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int BW = 1;
  localparam int PT = 40;
  localparam int ET = 300;
  localparam int ES = 20;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [1:0]    op;
  logic [AW-1:0] bank_base;
  logic [AW-1:0] target_addr;
  logic [DW-1:0] wr_data;
  logic          busy;
  logic          done;
  logic [1:0]    result;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata;
  logic          fl_rd;
  logic          fl_wr;
  logic          fl_wgate;

  int checks = 0;
  int errors = 0;

  nor_cmd_seq #(
    .ADDR_W      (AW),
    .LANES       (1),
    .BUS_WAIT    (BW),
    .ALT_UNLOCK  (1'b0),
    .PROG_TMO    (PT),
    .ERASE_TMO   (ET),
    .ERASE_SETTLE(ES)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .bank_base  (bank_base),
    .target_addr(target_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .fl_rdata   (fl_rdata),
    .fl_rd      (fl_rd),
    .fl_wr      (fl_wr),
    .fl_wgate   (fl_wgate)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural flash: status answers and a log of bus activity
  logic [DW-1:0] cur_val;
  logic [DW-1:0] exp_data;
  int            busy_polls;
  bit            erase_mode;
  int            rd_n;
  int            wr_n;
  logic [AW-1:0] wr_a [0:15];
  logic [DW-1:0] wr_d [0:15];
  bit            gate_seen;
  int            cyc;
  int            last_wr_end;
  int            first_poll_start;
  bit            prev_rd;
  bit            prev_wr;

  always_comb begin
    if (erase_mode) begin
      fl_rdata = (rd_n < busy_polls) ? 16'h0000 : 16'h0080;
    end else if (rd_n == 0) begin
      fl_rdata = cur_val;
    end else if ((rd_n - 1) < busy_polls) begin
      fl_rdata = exp_data ^ 16'h0080;
    end else begin
      fl_rdata = exp_data;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (fl_wgate) gate_seen = 1'b1;
    if (fl_wr && !prev_wr) begin
      if (wr_n < 16) begin
        wr_a[wr_n] = fl_addr;
        wr_d[wr_n] = fl_wdata;
      end
      wr_n = wr_n + 1;
    end
    if (!fl_wr && prev_wr) last_wr_end = cyc;
    if (fl_rd && !prev_rd && first_poll_start < 0 &&
        (erase_mode || rd_n > 0)) first_poll_start = cyc;
    if (!fl_rd && prev_rd) rd_n = rd_n + 1;
    prev_rd = fl_rd;
    prev_wr = fl_wr;
  end

  // expected write list
  logic [AW-1:0] ex_a [0:15];
  logic [DW-1:0] ex_d [0:15];
  int            ex_n;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ex_add(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ex_a[ex_n] = a;
    ex_d[ex_n] = d;
    ex_n = ex_n + 1;
  endtask

  function automatic logic [1:0] prog_code(input logic [DW-1:0] c, input logic [DW-1:0] d,
                                           input int polls);
    if ((c & d) != d) return 2'd2;
    if (polls > 100) return 2'd1;
    return 2'd0;
  endfunction

  task automatic build_expect(input logic [1:0] o, input logic [AW-1:0] b,
                              input logic [AW-1:0] t, input logic [DW-1:0] d,
                              input logic [1:0] code);
    ex_n = 0;
    if (o == 2'd0) begin
      if (code != 2'd2) begin
        ex_add(b + 24'h555, 16'h00AA);
        ex_add(b + 24'h2AA, 16'h0055);
        ex_add(b + 24'h555, 16'h00A0);
        ex_add(t, d);
        if (code == 2'd1) ex_add(t, 16'h00F0);
      end
    end else if (o == 2'd1) begin
      ex_add(b + 24'h555, 16'h00AA);
      ex_add(b + 24'h2AA, 16'h0055);
      ex_add(b + 24'h555, 16'h0080);
      ex_add(b + 24'h555, 16'h00AA);
      ex_add(b + 24'h2AA, 16'h0055);
      ex_add(t, 16'h0030);
      if (code == 2'd1) ex_add(b, 16'h00F0);
    end else begin
      ex_add(b, 16'h00F0);
    end
  endtask

  task automatic cmp_writes(input string req);
    chk({req, " write count"}, wr_n, ex_n);
    for (int i = 0; i < ex_n && i < wr_n && i < 16; i++) begin
      chk({req, " write addr"}, {8'h00, wr_a[i]}, {8'h00, ex_a[i]});
      chk({req, " write data"}, {16'h0, wr_d[i]}, {16'h0, ex_d[i]});
    end
  endtask

  logic [1:0] got_res;

  task automatic run_op(input logic [1:0] o, input logic [AW-1:0] b, input logic [AW-1:0] t,
                        input logic [DW-1:0] d, input logic [DW-1:0] c, input int polls,
                        input bit poke, input string req);
    int guard;
    erase_mode       = (o == 2'd1);
    cur_val          = c;
    exp_data         = d;
    busy_polls       = polls;
    rd_n             = 0;
    wr_n             = 0;
    gate_seen        = 1'b0;
    first_poll_start = -1;
    last_wr_end      = 0;
    @(negedge clk);
    op          = o;
    bank_base   = b;
    target_addr = t;
    wr_data     = d;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R10 busy after start"}, busy, 1'b1);
    if (poke) begin
      repeat (5) @(negedge clk);
      op        = 2'd2;
      bank_base = b ^ 24'h0F0000;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard = guard + 1;
    end
    got_res = result;
    chk({req, " R10 busy with done"}, busy, 1'b1);
    @(negedge clk);
    chk({req, " R10 busy falls"}, busy, 1'b0);
    chk({req, " R9 gate closed"}, fl_wgate, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [1:0]    eres;
    logic [1:0]    rop;
    logic [DW-1:0] rd;
    logic [DW-1:0] rc;
    logic [AW-1:0] rb;
    logic [AW-1:0] rt;
    int            rp;

    seed = $urandom(32'h00C0FFEE);
    rst_n = 1'b0; start = 1'b0; op = 2'd0;
    bank_base = '0; target_addr = '0; wr_data = '0;
    erase_mode = 1'b0; cur_val = '0; exp_data = '0; busy_polls = 0;
    rd_n = 0; wr_n = 0; gate_seen = 1'b0; cyc = 0; last_wr_end = 0;
    first_poll_start = -1; prev_rd = 1'b0; prev_wr = 1'b0; ex_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 rd", fl_rd, 1'b0);
    chk("R1 wr", fl_wr, 1'b0);
    chk("R1 gate", fl_wgate, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 program, passes after three busy reads
    run_op(2'd0, 24'h100000, 24'h100123, 16'h3C5A, 16'hFFFF, 3, 1'b0, "R2");
    build_expect(2'd0, 24'h100000, 24'h100123, 16'h3C5A, 2'd0);
    cmp_writes("R2");
    chk("R4 result", got_res, 2'd0);
    chk("R4 read count", rd_n, 5);

    // R4 bit 7 set in data, immediate match
    run_op(2'd0, 24'h200000, 24'h2000FE, 16'h00FF, 16'hFFFF, 0, 1'b0, "R4");
    chk("R4 single poll reads", rd_n, 2);
    chk("R4 single poll result", got_res, 2'd0);

    // R3 target not erased enough
    run_op(2'd0, 24'h100000, 24'h100010, 16'h00F1, 16'h00F0, 0, 1'b0, "R3");
    chk("R3 result", got_res, 2'd2);
    chk("R3 no writes", wr_n, 0);
    chk("R3 gate never opened", gate_seen, 1'b0);
    chk("R3 one read", rd_n, 1);

    // R5 program timeout
    run_op(2'd0, 24'h300000, 24'h300400, 16'h1234, 16'hFFFF, 100000, 1'b0, "R5");
    build_expect(2'd0, 24'h300000, 24'h300400, 16'h1234, 2'd1);
    cmp_writes("R5");
    chk("R5 result", got_res, 2'd1);

    // R6 erase, completes after four busy reads
    run_op(2'd1, 24'h400000, 24'h410000, 16'h0000, 16'h0000, 4, 1'b0, "R6");
    build_expect(2'd1, 24'h400000, 24'h410000, 16'h0000, 2'd0);
    cmp_writes("R6");
    chk("R6 result", got_res, 2'd0);
    chk("R6 poll reads", rd_n, 5);
    chk("R6 settle respected", (first_poll_start - last_wr_end) >= ES, 1'b1);

    // R7 erase timeout
    run_op(2'd1, 24'h500000, 24'h520000, 16'h0000, 16'h0000, 100000, 1'b0, "R7");
    build_expect(2'd1, 24'h500000, 24'h520000, 16'h0000, 2'd1);
    cmp_writes("R7");
    chk("R7 result", got_res, 2'd1);

    // R8 reset-to-read, both op codes
    run_op(2'd2, 24'h600000, 24'h600777, 16'h0000, 16'h0000, 0, 1'b0, "R8");
    build_expect(2'd2, 24'h600000, 24'h600777, 16'h0000, 2'd0);
    cmp_writes("R8");
    chk("R8 result", got_res, 2'd0);
    chk("R8 no reads", rd_n, 0);
    run_op(2'd3, 24'h700000, 24'h700001, 16'h0000, 16'h0000, 0, 1'b0, "R8 op3");
    build_expect(2'd3, 24'h700000, 24'h700001, 16'h0000, 2'd0);
    cmp_writes("R8 op3");

    // R10 start while busy is ignored
    run_op(2'd0, 24'h100000, 24'h100200, 16'h0F0F, 16'hFFFF, 2, 1'b1, "R10");
    build_expect(2'd0, 24'h100000, 24'h100200, 16'h0F0F, 2'd0);
    cmp_writes("R10");
    chk("R10 result", got_res, 2'd0);
    repeat (6) @(negedge clk);
    chk("R10 stays idle", busy, 1'b0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      rop = 2'($urandom % 3);
      rd  = 16'($urandom);
      rc  = (($urandom % 2) == 0) ? 16'hFFFF : 16'($urandom);
      rb  = {4'($urandom), 20'h00000};
      rt  = rb + 24'($urandom % 20'hFFFFF);
      rp  = int'($urandom % 5);
      if (rop == 2'd0) eres = prog_code(rc, rd, rp);
      else eres = 2'd0;
      run_op(rop, rb, rt, rd, rc, rp, 1'b0, "R2 R6 R8 random");
      build_expect(rop, rb, rt, rd, eres);
      cmp_writes("R2 R6 R8 random");
      chk("R3 R4 random result", got_res, eres);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule